// File: doc/BRIEF.md
# Interrupt status and mask unit for a storage-card host

This block holds the event flags of a storage-card host controller and turns them into one level-sensitive interrupt. Other engines, such as the command engine, the data engine and card detection, raise single-cycle event pulses. Each pulse sets a latched flag at its own bit position in a 32-bit status word. Software clears a flag by writing a zero to that bit; a one written to a bit leaves it as it is.

A companion 32-bit mask word decides which latched flags reach the interrupt line. A mask bit of 1 blocks its flag and a mask bit of 0 lets it through.

Six positions of the status word are not flags. They show live conditions that are sampled every cycle:
- card present
- write protect released
- DAT3 present
- card not busy
- one unassigned live line
- command register busy

These positions cannot be cleared and never cause an interrupt. All other unused positions read as zero.

Software reaches both words over a simple register port. The port has a write strobe, a select bit that picks the status word (0) or the mask word (1), write data, and a separate read select that returns the chosen word on the same cycle.

Top module: `cardhost_irq_status`

## Requirements
- R1: After reset the status word reads 0x00000000, the mask word reads 0x0B000300 and `irq` is low.
- R2: An event pulse on a flag position (bits 0, 2, 3, 4, 8, 9, 16–22, 24, 25, 27, 31) sets that status bit at the next clock edge. The bit stays set after the pulse ends.
- R3: A write to the status word (`wr_sel`=0) clears every flag bit where the write data is 0. Flag bits where the write data is 1 are left unchanged.
- R4: When an event pulse and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when some flag bit is set and its mask bit is 0. A mask bit of 1 blocks that flag.
- R6: The live positions (bits 5, 7, 10, 23, 29, 30) read the value `live_in` had one clock edge earlier. Status writes and event pulses do not change them, and they never drive `irq`.
- R7: The remaining positions (bits 1, 6, 11–15, 26, 28) read as zero in the status word. Event pulses and writes there have no effect.
- R8: A write to the mask word (`wr_sel`=1) stores only the flag positions. All other mask bits read as zero.
- R9: With the reset mask, error flags (bits 16–22 and 31) raise `irq`, while the flags at bits 8, 9, 24, 25 and 27 do not.
- R10: A card-insert event on bit 4 and the card-present live input on bit 5, driven in the same cycle, first show together in the same read after one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 mask |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 mask |
| rd_data | output | 32 | Selected word, combinational |
| evt_pulse | input | 32 | One-cycle event pulses, one per bit position |
| live_in | input | 32 | Live condition inputs, used at live positions only |
| irq | output | 1 | Level interrupt request |

## Verification
Every event pulse, status write, mask write and live input change is registered once. Its effect on `rd_data` and `irq` is therefore due one clock edge after the cycle in which it was driven. The read path and the interrupt path add no further delay.

The bench drives all stimulus on the falling edge and lets exactly one rising edge pass. It then samples on the next falling edge, with the stimulus already removed. Where timing matters (R6, R10), it also samples before that edge to confirm that nothing shows early. The same sampling point shows that a flag is still set after its pulse has ended.

// File: rtl/irqstat_pkg.sv
// Shared constants for the interrupt status unit.
// Assumes a 32-bit register word; bit positions are fixed by the status layout.
package irqstat_pkg;
    localparam int WORD_W = 32;

    // Positions that latch event pulses and can be acknowledged and masked.
    localparam logic [WORD_W-1:0] FLAG_POS_DEF  = 32'h8B7F_031D;
    // Positions that show live, sampled conditions.
    localparam logic [WORD_W-1:0] LIVE_POS_DEF  = 32'h6080_04A0;
    // Mask word after reset: bits 8, 9, 24, 25 and 27 blocked.
    localparam logic [WORD_W-1:0] MASK_RST_DEF  = 32'h0B00_0300;

    typedef enum logic [1:0] {
        POS_RESERVED = 2'd0,
        POS_FLAG     = 2'd1,
        POS_LIVE     = 2'd2
    } pos_kind_e;

    // Classify one bit position from the flag and live position vectors.
    function automatic pos_kind_e kind_of(input logic [WORD_W-1:0] flags,
                                          input logic [WORD_W-1:0] lives,
                                          input int idx);
        if (flags[idx])      return POS_FLAG;
        else if (lives[idx]) return POS_LIVE;
        else                 return POS_RESERVED;
    endfunction
endpackage

// File: rtl/irqstat_bit_cell.sv
// One position of the status word.
// FLAG: set by an event pulse, cleared by an acknowledge-zero write; the event wins a tie.
// LIVE: registered copy of a live input, not affected by writes or events.
// RESERVED: constant zero.
// Assumes a synchronous active-low reset.
module irqstat_bit_cell
    import irqstat_pkg::*;
#(
    parameter pos_kind_e KIND = POS_RESERVED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack_zero,
    input  logic live,
    output logic q
);
    generate
        if (KIND == POS_FLAG) begin : g_flag
            logic flag_q;
            logic unused_live;
            assign unused_live = live;
            // Latch events; clear on an acknowledge unless an event arrives in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)          flag_q <= 1'b0;
                else if (evt)        flag_q <= 1'b1;
                else if (ack_zero)   flag_q <= 1'b0;
            end
            assign q = flag_q;
        end else if (KIND == POS_LIVE) begin : g_live
            logic live_q;
            logic unused_wr;
            assign unused_wr = evt ^ ack_zero;
            // Sample the live condition every cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) live_q <= 1'b0;
                else        live_q <= live;
            end
            assign q = live_q;
        end else begin : g_rsvd
            logic unused_all;
            assign unused_all = clk ^ rst_n ^ evt ^ ack_zero ^ live;
            assign q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/irqstat_mask_reg.sv
// Interrupt mask word. Keeps only the flag positions; a stored 1 blocks that flag.
// Assumes a synchronous active-low reset to MASK_RST.
module irqstat_mask_reg
    import irqstat_pkg::*;
#(
    parameter int               W        = WORD_W,
    parameter logic [W-1:0]     FLAG_POS = FLAG_POS_DEF,
    parameter logic [W-1:0]     MASK_RST = MASK_RST_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);
    logic [W-1:0] mask_q;

    // Load new mask bits at flag positions only.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_q <= MASK_RST & FLAG_POS;
        else if (wr) mask_q <= wd & FLAG_POS;
    end

    assign q = mask_q;
endmodule

// File: rtl/irqstat_combine.sv
// Read multiplexer and interrupt reduction.
// Assumes the status word is already zero at reserved positions.
module irqstat_combine
    import irqstat_pkg::*;
#(
    parameter int           W        = WORD_W,
    parameter logic [W-1:0] FLAG_POS = FLAG_POS_DEF
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    output logic         irq
);
    logic [W-1:0] pending;

    // Unmasked flags only; live positions are excluded by FLAG_POS.
    always_comb pending = status & ~mask & FLAG_POS;

    // Raise one level request from any pending flag.
    always_comb irq = |pending;

    // Return the selected word.
    always_comb rd_data = rd_sel ? mask : status;
endmodule

// File: rtl/cardhost_irq_status.sv
// Top of the interrupt status unit: per-position status cells, mask word,
// read path and interrupt output.
// Assumes single-cycle event pulses and a synchronous active-low reset.
module cardhost_irq_status
    import irqstat_pkg::*;
#(
    parameter int                W        = WORD_W,
    parameter logic [W-1:0]      FLAG_POS = FLAG_POS_DEF,
    parameter logic [W-1:0]      LIVE_POS = LIVE_POS_DEF,
    parameter logic [W-1:0]      MASK_RST = MASK_RST_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] evt_pulse,
    input  logic [W-1:0] live_in,
    output logic         irq
);
    logic [W-1:0] status_all;
    logic [W-1:0] mask_q;
    logic         wr_status;
    logic         wr_mask;

    // Decode the write target.
    always_comb begin
        wr_status = wr_en && !wr_sel;
        wr_mask   = wr_en &&  wr_sel;
    end

    // One cell per position; the kind is picked from the position vectors.
    generate
        for (genvar i = 0; i < W; i++) begin : g_pos
            irqstat_bit_cell #(
                .KIND(kind_of(FLAG_POS, LIVE_POS, i))
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (evt_pulse[i]),
                .ack_zero (wr_status && !wr_data[i]),
                .live     (live_in[i]),
                .q        (status_all[i])
            );
        end
    endgenerate

    irqstat_mask_reg #(
        .W(W), .FLAG_POS(FLAG_POS), .MASK_RST(MASK_RST)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_mask),
        .wd    (wr_data),
        .q     (mask_q)
    );

    irqstat_combine #(
        .W(W), .FLAG_POS(FLAG_POS)
    ) u_comb (
        .status  (status_all),
        .mask    (mask_q),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .irq     (irq)
    );
endmodule

// File: rtl/cardhost_irq_status_chk.sv
// Property checker for cardhost_irq_status, attached by bind.
// Assumes the default position layout from irqstat_pkg.
module cardhost_irq_status_chk
    import irqstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] evt_pulse,
    input logic [WORD_W-1:0] live_in,
    input logic [WORD_W-1:0] rd_data,
    input logic              irq,
    input logic [WORD_W-1:0] status_view,
    input logic [WORD_W-1:0] mask_view
);
    localparam logic [WORD_W-1:0] RSVD = ~(FLAG_POS_DEF | LIVE_POS_DEF);

    // R2: an event pulse leaves its flag set at the next edge.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pulse & FLAG_POS_DEF)) |=>
        ((status_view & $past(evt_pulse & FLAG_POS_DEF)) == $past(evt_pulse & FLAG_POS_DEF)));

    // R3: data bits of zero clear flags that saw no event in the same cycle (R4).
    a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=>
        ((status_view & $past(FLAG_POS_DEF & ~wr_data & ~evt_pulse)) == '0));

    // R3: data bits of one keep flags that were set.
    a_r3_ones_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=>
        ((status_view & $past(status_view & wr_data & FLAG_POS_DEF)) ==
         $past(status_view & wr_data & FLAG_POS_DEF)));

    // R5: the request follows the unmasked flags.
    a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(status_view & ~mask_view & FLAG_POS_DEF)));

    // R6: live positions follow the input one edge later.
    a_r6_live_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_view & LIVE_POS_DEF) == ($past(live_in) & LIVE_POS_DEF)));

    // R7: reserved positions always read zero, whichever word is selected.
    a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & RSVD) == '0);

    // R8: the mask word holds nothing outside the flag positions.
    a_r8_mask_flags_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_view & ~FLAG_POS_DEF) == '0);
endmodule

bind cardhost_irq_status cardhost_irq_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .evt_pulse   (evt_pulse),
    .live_in     (live_in),
    .rd_data     (rd_data),
    .irq         (irq),
    .status_view (status_all),
    .mask_view   (mask_q)
);

// File: tb/cardhost_irq_status_test.sv
`timescale 1ns/1ps
// Directed bench for cardhost_irq_status: one task per scenario.
module cardhost_irq_status_test;
    localparam logic [31:0] FLAGS = 32'h8B7F_031D;
    localparam logic [31:0] LIVES = 32'h6080_04A0;
    localparam logic [31:0] RSVD  = 32'h1400_F842;
    localparam logic [31:0] MRST  = 32'h0B00_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] evt_pulse = '0;
    logic [31:0] live_in = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cardhost_irq_status uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_pulse(evt_pulse), .live_in(live_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Read one word at the current falling edge.
    task automatic rd(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    // Drive stimulus for one rising edge, then release it at the next falling edge.
    task automatic step(input logic we, input logic sel, input logic [31:0] wd,
                        input logic [31:0] ev);
        wr_en = we; wr_sel = sel; wr_data = wd; evt_pulse = ev;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; evt_pulse = '0;
    endtask

    task automatic clear_all();
        step(1'b1, 1'b0, 32'h0, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); check("R1 status", v, 32'h0);
        rd(1'b1, v); check("R1 mask", v, MRST);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_event();
        logic [31:0] v;
        step(1'b0, 1'b0, 32'h0, 32'h0000_0001);
        rd(1'b0, v); check("R2 set bit0", v, 32'h1);
        check("R2 irq bit0", {31'b0, irq}, 32'h1);
        step(1'b0, 1'b0, 32'h0, 32'h0);
        rd(1'b0, v); check("R2 held", v, 32'h1);
        step(1'b0, 1'b0, 32'h0, 32'h0001_0004);
        rd(1'b0, v); check("R2 accumulate", v, 32'h0001_0005);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        step(1'b1, 1'b0, 32'hFFFF_FFFE, 32'h0);
        rd(1'b0, v); check("R3 clear bit0 only", v, 32'h0001_0004);
        step(1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0);
        rd(1'b0, v); check("R3 ones keep", v, 32'h0001_0004);
        clear_all();
        rd(1'b0, v); check("R3 all cleared", v, 32'h0);
        check("R3 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        step(1'b0, 1'b0, 32'h0, 32'h0002_0004);
        step(1'b1, 1'b0, 32'h0, 32'h0002_0000);
        rd(1'b0, v); check("R4 event wins", v, 32'h0002_0000);
        clear_all();
        rd(1'b0, v); check("R4 cleared after", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        step(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0);
        rd(1'b1, v); check("R8 mask flags only", v, FLAGS);
        step(1'b0, 1'b0, 32'h0, 32'h0000_0008);
        check("R5 masked no irq", {31'b0, irq}, 32'h0);
        step(1'b1, 1'b1, 32'hFFFF_FFF7, 32'h0);
        check("R5 unmasked irq", {31'b0, irq}, 32'h1);
        step(1'b1, 1'b1, MRST, 32'h0);
        clear_all();
        check("R5 irq drops", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_defaults();
        step(1'b0, 1'b0, 32'h0, 32'h0B00_0300);
        check("R9 default-blocked flags", {31'b0, irq}, 32'h0);
        step(1'b0, 1'b0, 32'h0, 32'h8000_0000);
        check("R9 error bit31 irq", {31'b0, irq}, 32'h1);
        clear_all();
        step(1'b0, 1'b0, 32'h0, 32'h0040_0000);
        check("R9 error bit22 irq", {31'b0, irq}, 32'h1);
        clear_all();
    endtask

    task automatic t_live();
        logic [31:0] v;
        live_in = 32'hFFFF_FFFF;
        rd(1'b0, v); check("R6 not before edge", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(1'b0, v); check("R6 live shown", v, LIVES);
        check("R6 live no irq", {31'b0, irq}, 32'h0);
        step(1'b1, 1'b0, 32'h0, 32'h0);
        rd(1'b0, v); check("R6 ack ignored", v, LIVES);
        live_in = 32'h0;
        step(1'b0, 1'b0, 32'h0, LIVES);
        rd(1'b0, v); check("R6 event ignored", v, 32'h0);
        check("R6 event no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        step(1'b0, 1'b0, 32'h0, RSVD);
        rd(1'b0, v); check("R7 reserved events", v, 32'h0);
        check("R7 reserved irq", {31'b0, irq}, 32'h0);
        step(1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0);
        rd(1'b0, v); check("R7 reserved writes", v, 32'h0);
    endtask

    task automatic t_insert();
        logic [31:0] v;
        live_in = 32'h0000_0020;
        evt_pulse = 32'h0000_0010;
        rd(1'b0, v); check("R10 nothing early", v, 32'h0);
        @(posedge clk); @(negedge clk);
        evt_pulse = '0;
        rd(1'b0, v); check("R10 insert with present", v, 32'h0000_0030);
        check("R10 irq", {31'b0, irq}, 32'h1);
        live_in = 32'h0;
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_event();
        t_ack();
        t_collision();
        t_mask();
        t_defaults();
        t_live();
        t_reserved();
        t_insert();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule